// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block brings up a target FPGA by pushing its bitstream over a three-wire passive serial link. On a start request it pulls an active-low configuration request line low for a fixed number of cycles and then releases it. It waits a fixed wake-up interval and then polls the target's status input. Once the target reports ready, it takes the bitstream one byte at a time from a valid/ready stream and shifts each byte out on a single data line, with a configuration clock whose rising edge the target uses to capture each bit.

The byte count is latched with the start request. After the last bit the block waits a fixed settle interval, samples the target's done input, and reports the outcome. The outcome is either success or one of three error codes. It is held on the result outputs until the next start, and a one-cycle finish pulse marks the moment it becomes valid. All delays are parameters. The wake-up and settle intervals are given in microseconds and converted to cycles from the clock rate.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, cfg_req_n_o is 1, cclk_o, dout_o, busy_o, s_ready_o, finish_o and ok_o are 0, and err_o is 0.
- R2: A start_i seen while idle drives cfg_req_n_o low for exactly PULSE_CYC cycles, and then high. A start_i seen while busy_o is 1 is ignored, so a run has exactly one low pulse.
- R3: No cclk_o rising edge comes earlier than WAKE_US*CLK_MHZ cycles after cfg_req_n_o rises. If status_i is not high within STATUS_TMO_CYC cycles after that wait, the run ends with err_o = 1 (not ready), and no byte is accepted and no clock edge is produced.
- R4: Each accepted byte is sent as 8 bits, least-significant bit first. Each bit is valid on dout_o at a rising edge of cclk_o.
- R5: dout_o changes only when cclk_o is low both in the current cycle and in the previous cycle.
- R6: When the byte stream is never empty, consecutive cclk_o rising edges are exactly 2*HALF_CYC cycles apart, including across byte boundaries.
- R7: Exactly length_i bytes are accepted. s_ready_o is high only between bytes, so no byte is taken while one is partly shifted. Gaps in s_valid_i only pause the shifting.
- R8: If status_i is low while bytes are being shifted, the run aborts with err_o = 2. cclk_o drops low at once, and the block returns to idle.
- R9: done_i is sampled no earlier than SETTLE_US*CLK_MHZ cycles after the last cclk_o rising edge. If it is high, ok_o = 1 and err_o = 0. If it is low, ok_o = 0 and err_o = 3, with no retry.
- R10: A length_i of 0 accepts no byte and produces no clock edge. The block goes directly to the settle wait and the done check.
- R11: While idle, cclk_o is low and, after one cycle of idle, dout_o is low. ok_o and err_o hold the last outcome until the next accepted start_i, which clears them.
- R12: finish_o is high for exactly one cycle per run, in the cycle where the outcome first appears and busy_o returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a configuration run (taken only while idle) |
| length_i | input | LEN_W | Number of bitstream bytes, latched with start_i |
| s_data_i | input | 8 | Bitstream byte |
| s_valid_i | input | 1 | s_data_i holds a byte |
| s_ready_o | output | 1 | Byte is taken at this edge if s_valid_i is high |
| cfg_req_n_o | output | 1 | Active-low configuration request to the target |
| cclk_o | output | 1 | Configuration clock; the target captures on its rising edge |
| dout_o | output | 1 | Serial configuration data |
| status_i | input | 1 | Target status, high when ready and without error |
| done_i | input | 1 | Target done, high when configuration completed |
| busy_o | output | 1 | A run is in progress |
| finish_o | output | 1 | One-cycle pulse when the outcome becomes valid |
| ok_o | output | 1 | Last run succeeded |
| err_o | output | 2 | Last error: 0 none, 1 not ready, 2 status lost, 3 done missing |

## Verification
The assertions assume that status_i and done_i are already synchronous to clk. They also assume that s_valid_i and s_data_i change only away from the active edge. The bench drives all of these from a single falling-edge process, so every input settles half a cycle before the edge that samples it. The target model raises status a fixed number of cycles after the request is released. It drops status when a chosen number of clock edges has been seen, and raises done either when the last bit has been seen or a few cycles before the settle wait ends. This exercises every error path without any input race.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    typedef enum logic [1:0] {
        ERR_NONE        = 2'd0,
        ERR_NOT_READY   = 2'd1,
        ERR_STATUS_LOST = 2'd2,
        ERR_NO_DONE     = 2'd3
    } cfg_err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAKE,
        ST_POLL,
        ST_SHIFT,
        ST_SETTLE
    } cfg_state_e;

endpackage

// File: rtl/ps_wait_timer.sv
module ps_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i)
            cnt_d = '0;
        else if (cnt_q == TOP)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/ps_bit_shifter.sv
module ps_bit_shifter #(
    parameter int HALF_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush_i,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    output logic       ready_o,
    output logic       active_o,
    output logic       cclk_o,
    output logic       dout_o
);
    localparam int SLOT = 2 * HALF_CYC;
    localparam int CW = (SLOT > 2) ? $clog2(SLOT) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(SLOT - 1);
    localparam logic [CW-1:0] HI_CNT   = CW'(HALF_CYC);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        logic [2:0]    bitn;
        logic [7:0]    sh;
        logic          cclk;
        logic          dout;
    } shf_t;

    shf_t d, q;
    logic last_slot;

    always_comb begin
        d = q;
        last_slot = q.active && (q.cnt == LAST_CNT) && (q.bitn == 3'd7);
        ready_o   = !q.active || last_slot;
        if (q.active) begin
            // data moves one cycle after the clock has fallen
            if (q.cnt == '0) d.dout = q.sh[0];
            if (q.cnt == LAST_CNT) begin
                d.cnt  = '0;
                d.sh   = {1'b0, q.sh[7:1]};
                d.bitn = q.bitn + 3'd1;
                if (q.bitn == 3'd7) d.active = 1'b0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.dout = 1'b0;
        end
        if (load_i && ready_o) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.bitn   = '0;
            d.sh     = byte_i;
        end
        if (flush_i) begin
            d.active = 1'b0;
            d.cnt    = '0;
            d.bitn   = '0;
        end
        d.cclk = d.active && (d.cnt >= HI_CNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active_o = q.active;
    assign cclk_o   = q.cclk;
    assign dout_o   = q.dout;

    assert_data_moves_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_o) |-> (!cclk_o && !$past(cclk_o)))
        else $error("data line moved around a high clock");

    assert_load_when_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !flush_i) |-> ready_o)
        else $error("byte offered to a shifter that is mid-byte");

endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
    import ps_cfg_pkg::*;
#(
    parameter int CLK_MHZ        = 100,
    parameter int WAKE_US        = 60,
    parameter int SETTLE_US      = 10,
    parameter int PULSE_CYC      = 200,
    parameter int STATUS_TMO_CYC = 100000,
    parameter int HALF_CYC       = 2,
    parameter int LEN_W          = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] length_i,
    input  logic [7:0]       s_data_i,
    input  logic             s_valid_i,
    output logic             s_ready_o,
    output logic             cfg_req_n_o,
    output logic             cclk_o,
    output logic             dout_o,
    input  logic             status_i,
    input  logic             done_i,
    output logic             busy_o,
    output logic             finish_o,
    output logic             ok_o,
    output logic [1:0]       err_o
);
    localparam int WAKE_CYC   = CLK_MHZ * WAKE_US;
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int MAX_A      = (WAKE_CYC > SETTLE_CYC) ? WAKE_CYC : SETTLE_CYC;
    localparam int MAX_B      = (PULSE_CYC > STATUS_TMO_CYC) ? PULSE_CYC : STATUS_TMO_CYC;
    localparam int MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW         = $clog2(MAX_CYC + 1);
    localparam logic [TW-1:0] PULSE_LAST  = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] WAKE_LAST   = TW'(WAKE_CYC - 1);
    localparam logic [TW-1:0] TMO_LAST    = TW'(STATUS_TMO_CYC - 1);
    localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_CYC - 1);

    typedef struct packed {
        cfg_state_e       state;
        logic [LEN_W-1:0] rem;
        logic             cfg_n;
        logic             ok;
        cfg_err_e         err;
        logic             fin;
    } ctl_t;

    ctl_t d, q;
    logic [TW-1:0] tmr;
    logic tmr_clr, sh_load, sh_flush, sh_ready, sh_active;

    ps_wait_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .cnt_o (tmr)
    );

    ps_bit_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (sh_flush),
        .load_i   (sh_load),
        .byte_i   (s_data_i),
        .ready_o  (sh_ready),
        .active_o (sh_active),
        .cclk_o   (cclk_o),
        .dout_o   (dout_o)
    );

    always_comb begin
        d         = q;
        d.fin     = 1'b0;
        sh_flush  = 1'b0;
        s_ready_o = (q.state == ST_SHIFT) && (q.rem != '0) && sh_ready;
        sh_load   = s_ready_o && s_valid_i;
        case (q.state)
            ST_IDLE: if (start_i) begin
                d.state = ST_PULSE;
                d.cfg_n = 1'b0;
                d.ok    = 1'b0;
                d.err   = ERR_NONE;
                d.rem   = length_i;
            end
            ST_PULSE: if (tmr == PULSE_LAST) begin
                d.state = ST_WAKE;
                d.cfg_n = 1'b1;
            end
            ST_WAKE: if (tmr == WAKE_LAST) d.state = ST_POLL;
            ST_POLL: begin
                if (status_i) begin
                    d.state = ST_SHIFT;
                end else if (tmr == TMO_LAST) begin
                    d.state = ST_IDLE;
                    d.err   = ERR_NOT_READY;
                    d.fin   = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (!status_i) begin
                    sh_flush = 1'b1;
                    d.state  = ST_IDLE;
                    d.err    = ERR_STATUS_LOST;
                    d.fin    = 1'b1;
                end else begin
                    if (sh_load) d.rem = q.rem - 1'b1;
                    if (q.rem == '0 && !sh_active) d.state = ST_SETTLE;
                end
            end
            ST_SETTLE: if (tmr == SETTLE_LAST) begin
                d.state = ST_IDLE;
                d.fin   = 1'b1;
                if (done_i) d.ok  = 1'b1;
                else        d.err = ERR_NO_DONE;
            end
            default: d.state = ST_IDLE;
        endcase
        tmr_clr = (d.state != q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.cfg_n <= 1'b1;
            q.err   <= ERR_NONE;
        end else begin
            q <= d;
        end
    end

    assign cfg_req_n_o = q.cfg_n;
    assign busy_o      = (q.state != ST_IDLE);
    assign finish_o    = q.fin;
    assign ok_o        = q.ok;
    assign err_o       = q.err;

    assert_req_inside_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_req_n_o |-> busy_o)
        else $error("config request low outside a run");

    assert_clock_only_shifting_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_o |-> (q.state == ST_SHIFT))
        else $error("configuration clock high outside the shift phase");

    assert_idle_rest_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cfg_req_n_o && !cclk_o))
        else $error("idle outputs not at rest");

    assert_idle_data_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> !dout_o)
        else $error("data line high while idle");

    assert_finish_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |=> (!finish_o && !busy_o))
        else $error("finish pulse longer than one cycle");

    assert_ok_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> (err_o == 2'd0))
        else $error("success reported with an error code");

endmodule

// File: tb/tb_ps_cfg_master.sv
module tb_ps_cfg_master;
    localparam int HALF   = 2;
    localparam int WAKE   = 60;
    localparam int SETTLE = 10;
    localparam int PULSE  = 4;
    localparam int TMO    = 40;
    localparam int ST_DLY = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] length_i = '0;
    logic [7:0] s_data_i = '0;
    logic       s_valid_i = 1'b0;
    logic       s_ready_o, cfg_req_n_o, cclk_o, dout_o;
    logic       status_i = 1'b0;
    logic       done_i = 1'b0;
    logic       busy_o, finish_o, ok_o;
    logic [1:0] err_o;

    ps_cfg_master #(
        .CLK_MHZ(1), .WAKE_US(WAKE), .SETTLE_US(SETTLE), .PULSE_CYC(PULSE),
        .STATUS_TMO_CYC(TMO), .HALF_CYC(HALF), .LEN_W(8)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .length_i(length_i),
        .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
        .cfg_req_n_o(cfg_req_n_o), .cclk_o(cclk_o), .dout_o(dout_o),
        .status_i(status_i), .done_i(done_i), .busy_o(busy_o),
        .finish_o(finish_o), .ok_o(ok_o), .err_o(err_o)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    bit all_done = 1'b0;

    // monitor and target model state
    int cyc = 0, rises = 0, viol = 0, per_bad = 0, cfg_low = 0, cfg_falls = 0;
    int cfg_rise = 0, first_rise = 0, last_rise = 0, rel = 0, hs = 0, hs_bad = 0;
    int fin_seen = 0, fin_cyc = 0, fin_count = 0, ptr = 0, s_len = 0, exp_bits = 0;
    int st_mode = 0, done_mode = 0, drop_at = 0;
    bit chk_period = 1'b0, gap_m = 1'b0, r_ok = 1'b0;
    logic [1:0] r_err = '0;
    logic p_cclk = 1'b0, p_dout = 1'b0, p_cfg = 1'b1;
    logic [7:0] bytes [16];
    logic [7:0] cap [16];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (cclk_o && !p_cclk) begin
                if (rises < 128) cap[rises / 8][rises % 8] = dout_o;
                if (rises == 0) first_rise = cyc;
                else if (chk_period && (cyc - last_rise) != 2 * HALF) per_bad++;
                last_rise = cyc;
                rises++;
            end
            if (dout_o != p_dout && (cclk_o || p_cclk)) viol++;
            if (!cfg_req_n_o) cfg_low++;
            if (!cfg_req_n_o && p_cfg) cfg_falls++;
            if (cfg_req_n_o && !p_cfg) cfg_rise = cyc;
            if (!cfg_req_n_o) rel = 0; else if (busy_o) rel++;
            if (finish_o) begin
                fin_seen = 1; fin_cyc = cyc; fin_count++;
                r_ok = ok_o; r_err = err_o;
            end
            status_i = (st_mode != 0) && busy_o && cfg_req_n_o && (rel >= ST_DLY)
                       && !(st_mode == 2 && rises >= drop_at);
            done_i = (done_mode == 1 && rises >= exp_bits) ||
                     (done_mode == 2 && rises >= exp_bits && (cyc - last_rise) >= SETTLE - 3);
            begin
                bit v;
                v = (ptr < s_len) && (!gap_m || (cyc % 3 == 0));
                s_valid_i = v;
                s_data_i  = v ? bytes[ptr] : 8'h00;
                if (v && s_ready_o) begin
                    hs++;
                    if (rises % 8 != 0) hs_bad++;
                    ptr++;
                end
            end
        end
        p_cclk = cclk_o; p_dout = dout_o; p_cfg = cfg_req_n_o;
    end

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    logic [1:0] err_after_start;

    task automatic run(input int n, input bit gap, input int stm, input int dm,
                       input int drop, input bit restart);
        @(negedge clk);
        rises = 0; viol = 0; per_bad = 0; cfg_low = 0; cfg_falls = 0; hs = 0;
        hs_bad = 0; fin_seen = 0; fin_count = 0; ptr = 0; s_len = n;
        chk_period = !gap; gap_m = gap; st_mode = stm; done_mode = dm;
        drop_at = drop; exp_bits = n * 8;
        for (int i = 0; i < 16; i++) cap[i] = 8'h00;
        length_i = 8'(n);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        err_after_start = err_o;
        if (restart) begin
            repeat (20) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int i = 0; i < 5000 && fin_seen == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check(cfg_req_n_o == 1'b1, "R1 cfg_req_n", cfg_req_n_o, 1);
        check(!cclk_o && !dout_o, "R1 clock/data", {cclk_o, dout_o}, 0);
        check(!busy_o && !s_ready_o && !finish_o, "R1 busy/ready/finish",
              {busy_o, s_ready_o, finish_o}, 0);
        check(!ok_o && err_o == 2'd0, "R1 result", {ok_o, err_o}, 0);
    endtask

    task automatic t_basic();
        bytes[0] = 8'hA5; bytes[1] = 8'h3C; bytes[2] = 8'h81;
        run(3, 1'b0, 1, 1, 0, 1'b0);
        for (int i = 0; i < 3; i++) check(cap[i] == bytes[i], "R4 byte lsb first", cap[i], bytes[i]);
        check(rises == 24, "R4 rising edges", rises, 24);
        check(cfg_low == PULSE, "R2 pulse length", cfg_low, PULSE);
        check(first_rise - cfg_rise >= WAKE, "R3 wake before clock", first_rise - cfg_rise, WAKE);
        check(per_bad == 0, "R6 back-to-back period", per_bad, 0);
        check(viol == 0, "R5 data moved with clock high", viol, 0);
        check(hs == 3 && hs_bad == 0, "R7 byte acceptance", hs * 100 + hs_bad, 300);
        check(r_ok && r_err == 2'd0, "R9 success", {r_ok, r_err}, 4);
        check(fin_cyc - last_rise >= SETTLE, "R9 settle wait", fin_cyc - last_rise, SETTLE);
        check(fin_count == 1, "R12 finish pulse width", fin_count, 1);
        check(ok_o && !busy_o, "R11 result held", {ok_o, busy_o}, 2);
        check(!cclk_o && !dout_o && cfg_req_n_o, "R11 idle rest", {cclk_o, dout_o, cfg_req_n_o}, 1);
    endtask

    task automatic t_gaps();
        bytes[0] = 8'h01; bytes[1] = 8'hFE; bytes[2] = 8'h5A; bytes[3] = 8'hC3;
        run(4, 1'b1, 1, 1, 0, 1'b0);
        for (int i = 0; i < 4; i++) check(cap[i] == bytes[i], "R7 bytes with gaps", cap[i], bytes[i]);
        check(hs == 4 && hs_bad == 0, "R7 no mid-byte accept", hs * 100 + hs_bad, 400);
        check(viol == 0, "R5 data with gaps", viol, 0);
        check(r_ok, "R9 success with gaps", r_ok, 1);
    endtask

    task automatic t_not_ready();
        run(2, 1'b0, 0, 1, 0, 1'b0);
        check(r_err == 2'd1 && !r_ok, "R3 not-ready code", r_err, 1);
        check(rises == 0 && hs == 0, "R3 nothing shifted", rises + hs, 0);
        check((fin_cyc - cfg_rise >= WAKE + TMO - 1) && (fin_cyc - cfg_rise <= WAKE + TMO + 2),
              "R3 timeout length", fin_cyc - cfg_rise, WAKE + TMO);
    endtask

    task automatic t_lost();
        bytes[0] = 8'hFF; bytes[1] = 8'hFF; bytes[2] = 8'hFF;
        run(3, 1'b0, 2, 1, 12, 1'b0);
        check(r_err == 2'd2 && !r_ok, "R8 status-lost code", r_err, 2);
        check(rises <= 13, "R8 clock stops", rises, 12);
        check(!busy_o && !cclk_o, "R8 back to idle", {busy_o, cclk_o}, 0);
        check(viol == 0, "R5 data at abort", viol, 0);
    endtask

    task automatic t_no_done();
        bytes[0] = 8'h42;
        run(1, 1'b0, 1, 0, 0, 1'b0);
        check(r_err == 2'd3 && !r_ok, "R9 done-missing code", r_err, 3);
        check(err_o == 2'd3, "R11 error held", err_o, 3);
    endtask

    task automatic t_len0();
        run(0, 1'b0, 1, 1, 0, 1'b0);
        check(err_after_start == 2'd0, "R11 start clears result", err_after_start, 0);
        check(rises == 0 && hs == 0, "R10 nothing shifted", rises + hs, 0);
        check(r_ok && r_err == 2'd0, "R10 empty run succeeds", {r_ok, r_err}, 4);
    endtask

    task automatic t_settle();
        bytes[0] = 8'h96; bytes[1] = 8'h69;
        run(2, 1'b0, 1, 2, 0, 1'b0);
        check(r_ok, "R9 done rising inside settle", r_ok, 1);
        check(cap[0] == 8'h96 && cap[1] == 8'h69, "R4 two bytes", {cap[0], cap[1]}, 16'h9669);
    endtask

    task automatic t_restart();
        bytes[0] = 8'h0F; bytes[1] = 8'hF0;
        run(2, 1'b0, 1, 1, 0, 1'b1);
        check(cfg_falls == 1, "R2 start while busy ignored", cfg_falls, 1);
        check(hs == 2 && r_ok, "R2 run unaffected", hs, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!all_done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_gaps();
        t_not_ready();
        t_lost();
        t_no_done();
        t_len0();
        t_settle();
        t_restart();
        all_done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule